// File: doc/BRIEF.md
# Host-Commanded Power Mode Controller

This block sequences the power state of a peripheral that a host drives over a serial link. The host side is already decoded: the controller sees a one-cycle command strobe with a 3-bit command code. It keeps one of four modes (ACTIVE, STANDBY, SLEEP, POWERDOWN). It drives an enable for the graphics, audio and touch engines, a core reset, a one-cycle mode-change strobe for downstream clock gating, and a one-cycle error flag for commands it refuses.

Two inputs override the host. A supply-not-ready indication holds the core in reset and parks the mode in SLEEP. An asynchronous active-low power-down pin forces POWERDOWN from any mode, and it removes the engine enable at once, without waiting for its synchronizer. The controller times how long the pin stays low. A short low pulse only leaves the block in POWERDOWN. A pulse that reaches the minimum hold time works as a hardware reset when the pin returns high: a core reset burst, then SLEEP.

Mode encoding: ACTIVE=2'b00, STANDBY=2'b01, SLEEP=2'b10, POWERDOWN=2'b11. Command codes: 1=wake, 2=standby, 3=sleep, 4=power-down. Codes 0, 5, 6 and 7 are unknown.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst` or `por_busy_i` is high, `mode_o` becomes SLEEP (2'b10) and `core_rst_o` is high from the next clock edge. Once both are low, `core_rst_o` falls one edge later and the mode stays SLEEP.
- R2: A command with code 1 (wake), sent while the mode is STANDBY, SLEEP or POWERDOWN, sets `mode_o` to ACTIVE (2'b00) on the edge that samples the strobe.
- R3: In ACTIVE, code 2 moves the mode to STANDBY (2'b01), code 3 to SLEEP (2'b10) and code 4 to POWERDOWN (2'b11), on the edge that samples the strobe.
- R4: A command that names the current mode, any non-wake command outside ACTIVE, and the unknown codes 0, 5, 6 and 7 leave the mode unchanged. Each raises `cmd_err_o` for exactly one cycle, in the cycle after the strobe.
- R5: `engine_en_o` is high exactly when `mode_o` is ACTIVE and `pd_n_i` is high.
- R6: Driving `pd_n_i` low drops `engine_en_o` at once, without a clock edge. `mode_o` reads POWERDOWN by the third clock edge after the fall. While the synchronized pin is low, commands are discarded and raise no error.
- R7: A low pulse on `pd_n_i` shorter than the minimum hold time leaves the mode in POWERDOWN after the pin returns high, and `core_rst_o` stays low.
- R8: A low pulse at least as long as the minimum hold time (CLK_KHZ*PD_MIN_US/1000 cycles) makes `core_rst_o` pulse high for RST_CYC cycles after the release. The mode then settles in SLEEP.
- R9: `mode_chg_o` is high for one cycle in exactly those cycles where `mode_o` differs from its value in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por_busy_i | input | 1 | High while the supply is not yet stable |
| pd_n_i | input | 1 | Asynchronous active-low power-down pin |
| cmd_vld_i | input | 1 | One-cycle strobe for a decoded host command |
| cmd_code_i | input | 3 | Command code (1 wake, 2 standby, 3 sleep, 4 power-down) |
| mode_o | output | 2 | Current mode |
| engine_en_o | output | 1 | Enable for the graphics, audio and touch engines |
| core_rst_o | output | 1 | Core reset |
| mode_chg_o | output | 1 | One-cycle strobe on every mode change |
| cmd_err_o | output | 1 | One-cycle flag for a refused command |

## Verification
The assertions check on every cycle that the engine enable appears only in ACTIVE and never while the pin is low. They also check that the core reset implies SLEEP and follows the supply flag, that the change strobe matches a real change of mode, and that a refused command never moves the mode. The bench scenarios cover the rest. Random command streams are compared with a reference mode model. Directed cases cover the power-down pin: short and long low pulses, the reset burst after a long one, and commands discarded while the pin is low.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [1:0] {
    MODE_ACTIVE  = 2'b00,
    MODE_STANDBY = 2'b01,
    MODE_SLEEP   = 2'b10,
    MODE_PDOWN   = 2'b11
  } mode_e;

  localparam int CMD_W = 3;

  localparam logic [CMD_W-1:0] CMD_WAKE  = 3'd1;
  localparam logic [CMD_W-1:0] CMD_STBY  = 3'd2;
  localparam logic [CMD_W-1:0] CMD_SLEEP = 3'd3;
  localparam logic [CMD_W-1:0] CMD_PDOWN = 3'd4;

  typedef struct packed {
    logic wake;
    logic to_stby;
    logic to_sleep;
    logic to_pdown;
    logic unknown;
  } cmd_t;

endpackage

// File: rtl/pwr_pd_sync.sv
module pwr_pd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pd_n_async,
  output logic pd_low
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pd_n_async};
    end
  end

  assign pd_low = ~sync_q[STAGES-1];

endmodule

// File: rtl/pwr_pd_timer.sv
module pwr_pd_timer #(
  parameter int LOW_CYC = 60000,
  parameter int RST_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic pd_low,
  output logic pin_rst
);

  localparam int CW  = $clog2(LOW_CYC + 1);
  localparam int RCW = $clog2(RST_CYC + 1);
  localparam logic [CW-1:0]  LOW_MAX = CW'(LOW_CYC);
  localparam logic [RCW-1:0] RST_LEN = RCW'(RST_CYC);

  logic [CW-1:0]  low_cnt;
  logic [RCW-1:0] rst_cnt;
  logic           long_release;

  assign long_release = !pd_low && (low_cnt == LOW_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= '0;
    end else if (pd_low) begin
      if (low_cnt != LOW_MAX) low_cnt <= low_cnt + 1'b1;
    end else begin
      low_cnt <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_cnt <= '0;
    end else if (long_release) begin
      rst_cnt <= RST_LEN;
    end else if (rst_cnt != '0) begin
      rst_cnt <= rst_cnt - 1'b1;
    end
  end

  assign pin_rst = (rst_cnt != '0);

endmodule

// File: rtl/pwr_cmd_decode.sv
module pwr_cmd_decode
  import pwr_mode_pkg::*;
(
  input  logic             vld,
  input  logic [CMD_W-1:0] code,
  output cmd_t             cmd
);

  always_comb begin
    cmd = '0;
    if (vld) begin
      unique case (code)
        CMD_WAKE:  cmd.wake     = 1'b1;
        CMD_STBY:  cmd.to_stby  = 1'b1;
        CMD_SLEEP: cmd.to_sleep = 1'b1;
        CMD_PDOWN: cmd.to_pdown = 1'b1;
        default:   cmd.unknown  = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  hold,
  input  logic  pd_low,
  input  cmd_t  cmd,
  output mode_e mode_q,
  output logic  en_q,
  output logic  chg_q,
  output logic  err_q,
  output logic  core_rst_q
);

  mode_e mode_d;
  logic  err_d;
  logic  any_cmd;

  assign any_cmd = cmd.wake | cmd.to_stby | cmd.to_sleep | cmd.to_pdown | cmd.unknown;

  always_comb begin
    mode_d = mode_q;
    err_d  = 1'b0;
    if (hold) begin
      mode_d = MODE_SLEEP;
    end else if (pd_low) begin
      mode_d = MODE_PDOWN;
    end else if (any_cmd) begin
      if (mode_q == MODE_ACTIVE) begin
        if (cmd.to_stby)       mode_d = MODE_STANDBY;
        else if (cmd.to_sleep) mode_d = MODE_SLEEP;
        else if (cmd.to_pdown) mode_d = MODE_PDOWN;
        else                   err_d  = 1'b1;
      end else begin
        if (cmd.wake) mode_d = MODE_ACTIVE;
        else          err_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= MODE_SLEEP;
      en_q       <= 1'b0;
      chg_q      <= 1'b0;
      err_q      <= 1'b0;
      core_rst_q <= 1'b1;
    end else begin
      mode_q     <= mode_d;
      en_q       <= (mode_d == MODE_ACTIVE);
      chg_q      <= (mode_d != mode_q);
      err_q      <= err_d;
      core_rst_q <= hold;
    end
  end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int CLK_KHZ    = 12000,
  parameter int PD_MIN_US  = 5000,
  parameter int RST_CYC    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             por_busy_i,
  input  logic             pd_n_i,
  input  logic             cmd_vld_i,
  input  logic [CMD_W-1:0] cmd_code_i,
  output logic [1:0]       mode_o,
  output logic             engine_en_o,
  output logic             core_rst_o,
  output logic             mode_chg_o,
  output logic             cmd_err_o
);

  localparam int LOW_CYC = (CLK_KHZ * PD_MIN_US) / 1000;

  logic  pd_low;
  logic  pin_rst;
  logic  hold;
  logic  en_q;
  cmd_t  cmd;
  mode_e mode_q;

  pwr_pd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .pd_n_async (pd_n_i),
    .pd_low     (pd_low)
  );

  pwr_pd_timer #(.LOW_CYC(LOW_CYC), .RST_CYC(RST_CYC)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .pd_low  (pd_low),
    .pin_rst (pin_rst)
  );

  pwr_cmd_decode u_dec (
    .vld  (cmd_vld_i),
    .code (cmd_code_i),
    .cmd  (cmd)
  );

  assign hold = por_busy_i | pin_rst;

  pwr_mode_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .hold       (hold),
    .pd_low     (pd_low),
    .cmd        (cmd),
    .mode_q     (mode_q),
    .en_q       (en_q),
    .chg_q      (mode_chg_o),
    .err_q      (cmd_err_o),
    .core_rst_q (core_rst_o)
  );

  assign mode_o      = mode_q;
  assign engine_en_o = en_q & pd_n_i;

endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       por_busy_i,
  input logic       pd_n_i,
  input logic [1:0] mode_o,
  input logic       engine_en_o,
  input logic       core_rst_o,
  input logic       mode_chg_o,
  input logic       cmd_err_o
);

  p_en_needs_active_r5: assert property (@(posedge clk) disable iff (rst)
    engine_en_o |-> (mode_o == 2'b00));

  p_pin_kills_en_r6: assert property (@(posedge clk) disable iff (rst)
    !pd_n_i |-> !engine_en_o);

  p_supply_holds_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(por_busy_i) |-> core_rst_o);

  p_reset_means_sleep_r1: assert property (@(posedge clk) disable iff (rst)
    core_rst_o |-> (mode_o == 2'b10));

  p_chg_on_change_r9: assert property (@(posedge clk) disable iff (rst)
    mode_chg_o |-> (mode_o != $past(mode_o)));

  p_no_chg_when_still_r9: assert property (@(posedge clk) disable iff (rst)
    !mode_chg_o |-> (mode_o == $past(mode_o)));

  p_err_keeps_mode_r4: assert property (@(posedge clk) disable iff (rst)
    cmd_err_o |-> (!mode_chg_o && (mode_o == $past(mode_o))));

  p_err_one_cycle_r4: assert property (@(posedge clk) disable iff (rst)
    $past(cmd_err_o) && cmd_err_o |-> (mode_o == $past(mode_o)));

endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .por_busy_i  (por_busy_i),
  .pd_n_i      (pd_n_i),
  .mode_o      (mode_o),
  .engine_en_o (engine_en_o),
  .core_rst_o  (core_rst_o),
  .mode_chg_o  (mode_chg_o),
  .cmd_err_o   (cmd_err_o)
);

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb;

  localparam int CLK_KHZ   = 50000;
  localparam int PD_MIN_US = 1;
  localparam int RST_CYC   = 4;
  localparam int LOW_CYC   = (CLK_KHZ * PD_MIN_US) / 1000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       por_busy_i = 1'b1;
  logic       pd_n_i = 1'b1;
  logic       cmd_vld_i = 1'b0;
  logic [2:0] cmd_code_i = 3'd0;
  logic [1:0] mode_o;
  logic       engine_en_o, core_rst_o, mode_chg_o, cmd_err_o;

  int checks = 0;
  int errors = 0;
  logic seen_rst = 1'b0;
  logic [1:0] exp_mode;

  always #10 clk = ~clk;

  pwr_mode_ctrl #(.CLK_KHZ(CLK_KHZ), .PD_MIN_US(PD_MIN_US), .RST_CYC(RST_CYC)) u_dut (
    .clk(clk), .rst(rst), .por_busy_i(por_busy_i), .pd_n_i(pd_n_i),
    .cmd_vld_i(cmd_vld_i), .cmd_code_i(cmd_code_i), .mode_o(mode_o),
    .engine_en_o(engine_en_o), .core_rst_o(core_rst_o),
    .mode_chg_o(mode_chg_o), .cmd_err_o(cmd_err_o)
  );

  always @(negedge clk) if (core_rst_o) seen_rst <= 1'b1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] model_next(input logic [1:0] m, input logic [2:0] c);
    if (m == 2'b00) begin
      case (c)
        3'd2: return 2'b01;
        3'd3: return 2'b10;
        3'd4: return 2'b11;
        default: return m;
      endcase
    end
    return (c == 3'd1) ? 2'b00 : m;
  endfunction

  task automatic send(input logic [2:0] code, input string req);
    logic [1:0] nm;
    nm = model_next(exp_mode, code);
    @(negedge clk);
    cmd_vld_i = 1'b1; cmd_code_i = code;
    @(negedge clk);
    cmd_vld_i = 1'b0;
    chk({req, " mode"}, mode_o, nm);
    chk({req, " err R4"}, cmd_err_o, nm == exp_mode);
    chk({req, " chg R9"}, mode_chg_o, nm != exp_mode);
    chk("R5 enable", engine_en_o, nm == 2'b00);
    exp_mode = nm;
    @(negedge clk);
    chk("R4 err one cycle", cmd_err_o, 1'b0);
    chk("R9 chg one cycle", mode_chg_o, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 reset core_rst", core_rst_o, 1'b1);
    chk("R1 reset mode", mode_o, 2'b10);
    chk("R5 reset enable", engine_en_o, 1'b0);
    rst = 1'b0;
    // command during supply hold is discarded
    cmd_vld_i = 1'b1; cmd_code_i = 3'd1;
    repeat (3) @(negedge clk);
    cmd_vld_i = 1'b0;
    chk("R1 por core_rst", core_rst_o, 1'b1);
    chk("R1 por mode", mode_o, 2'b10);
    chk("R1 por no err", cmd_err_o, 1'b0);
    por_busy_i = 1'b0;
    @(negedge clk);
    chk("R1 core_rst release", core_rst_o, 1'b0);
    chk("R1 mode after por", mode_o, 2'b10);
    chk("R9 no chg after por", mode_chg_o, 1'b0);
    exp_mode = 2'b10;

    // directed
    send(3'd2, "R4 stby from sleep");
    send(3'd1, "R2 wake from sleep");
    send(3'd1, "R4 wake in active");
    send(3'd6, "R4 unknown in active");
    send(3'd2, "R3 to standby");
    send(3'd1, "R2 wake from standby");
    send(3'd4, "R3 to powerdown");
    send(3'd0, "R4 unknown in powerdown");
    send(3'd1, "R2 wake from powerdown");
    send(3'd3, "R3 to sleep");
    send(3'd1, "R2 wake again");

    // random
    for (int i = 0; i < 200; i++) begin
      send(3'($urandom % 8), "R2/R3 random");
      if (($urandom % 4) == 0) begin
        @(negedge clk);
        chk("R9 idle no chg", mode_chg_o, 1'b0);
        chk("R9 idle stable", mode_o, exp_mode);
      end
    end
    if (exp_mode != 2'b00) send(3'd1, "R2 wake before pin");

    // short pin pulse
    seen_rst = 1'b0;
    @(negedge clk);
    pd_n_i = 1'b0;
    #1;
    chk("R6 enable drops at once", engine_en_o, 1'b0);
    repeat (3) @(negedge clk);
    chk("R6 mode powerdown", mode_o, 2'b11);
    cmd_vld_i = 1'b1; cmd_code_i = 3'd1;
    @(negedge clk);
    cmd_vld_i = 1'b0;
    chk("R6 cmd discarded mode", mode_o, 2'b11);
    chk("R6 cmd discarded no err", cmd_err_o, 1'b0);
    repeat (5) @(negedge clk);
    pd_n_i = 1'b1;
    repeat (RST_CYC + 8) @(negedge clk);
    chk("R7 short stays powerdown", mode_o, 2'b11);
    chk("R7 short no core reset", seen_rst, 1'b0);
    chk("R5 enable off in powerdown", engine_en_o, 1'b0);
    exp_mode = 2'b11;
    send(3'd1, "R2 wake after short pulse");

    // long pin pulse
    seen_rst = 1'b0;
    @(negedge clk);
    pd_n_i = 1'b0;
    repeat (LOW_CYC + 10) @(negedge clk);
    chk("R8 powerdown during hold", mode_o, 2'b11);
    chk("R8 no reset while low", seen_rst, 1'b0);
    pd_n_i = 1'b1;
    repeat (RST_CYC + 8) @(negedge clk);
    chk("R8 core reset burst seen", seen_rst, 1'b1);
    chk("R8 core reset ended", core_rst_o, 1'b0);
    chk("R8 settles in sleep", mode_o, 2'b10);
    exp_mode = 2'b10;
    send(3'd1, "R2 wake after long pulse");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule